// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block walks a list of conversion commands held in a small command memory and hands them one at a time to an external conversion engine. The memory is divided into two queues by a programmable boundary index: queue 1 occupies the entries below the boundary, and queue 2 starts at the boundary. Queue 1 always has priority. For each command the block presents the channel number and a two-bit sample-time code to the engine and pulses a start strobe. It then waits for the engine's done strobe and writes the returned result into a result table at the command's own index.

Each queue is armed by software and started by a trigger source chosen per queue: a software strike, a periodic timer tick, a rising edge on an external line, or (queue 1 only) a gate level. A command can carry a pause mark, which parks the queue after that command until the next trigger. A queue pass ends when one of three things happens: the command has channel 63, queue 1 reaches the boundary index, or the last memory entry has been converted. The block keeps sticky completion, pause and trigger-overrun flags per queue and raises per-queue interrupt requests. A queue 1 trigger that arrives while queue 2 is running aborts the conversion in progress. After queue 1 finishes, queue 2 starts over at the beginning of the subqueue it was executing.

Top module: `dualq_sequencer`

## Requirements
- R1: A command word is 9 bits: bit 8 is the pause mark, bits 7:6 the sample-time code, bits 5:0 the channel. When a command is launched, `convCh` and `convSt` carry its channel and code, and `convStart` pulses high for exactly one cycle.
- R2: Commands of the active queue are converted in ascending index order. On each `convDone`, `resWr` pulses with `resIdx` equal to the command's index and `resData` equal to `convResult`.
- R3: After a command with the pause mark completes, its queue stops, `pauseFlag` for that queue sets, and no further commands of that queue run until its next trigger. That trigger resumes the queue at the following index.
- R4: A command whose channel is 63 is not converted. It ends its queue's pass and sets that queue's `doneFlag`.
- R5: Queue 1 runs from index 0 and ends its pass on reaching index `q2Start`. With `q2Start` = 0, queue 1 completes with no conversion.
- R6: Either queue ends its pass after converting the last memory index (DEPTH-1), and sets its `doneFlag`.
- R7: A queue 1 trigger while queue 2 is converting asserts `convAbort` in that cycle. No result is written for the aborted command, and queue 1 runs next.
- R8: After a preemption, queue 2 restarts at the first command of its current subqueue. That is the index after its most recent pause, or `q2Start` if it has not paused in this pass.
- R9: With `scanCont` low, a completed pass disarms the queue, and its triggers are ignored until `armSet` is pulsed. With `scanCont` high, the queue stays armed after every pass.
- R10: Trigger source codes (`q1Src`/`q2Src`): 0 = `swTrig` pulse, 1 = `timerTick`, 2 = rising edge of `extTrig`, 3 = `gateIn` high (queue 1 only; code 3 never triggers queue 2). Events from unselected sources are ignored.
- R11: A trigger to a queue that is running (started, not paused) is ignored and sets that queue's `ovrFlag`. In gate mode, no overrun is flagged.
- R12: Flags are sticky until cleared by writing one to `flagClr`: bits 1:0 clear done, bits 3:2 clear pause, bits 5:4 clear overrun (bit 0/2/4 for queue 1). `irq[q]` = (`doneFlag[q]` and `doneIe[q]`) or (`pauseFlag[q]` and `pauseIe[q]`).
- R13: After reset all flags, `irq`, `convStart`, `convAbort` and `resWr` are low and both queues are idle and disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Command memory write enable |
| cmdAddr | input | IDX_W | Command memory write index |
| cmdData | input | 9 | Command word to write |
| q2Start | input | IDX_W | First index of queue 2 (end of queue 1) |
| q1Src | input | 2 | Queue 1 trigger source code |
| q2Src | input | 2 | Queue 2 trigger source code |
| scanCont | input | 2 | Per-queue continuous-scan select |
| armSet | input | 2 | Per-queue arm pulse |
| swTrig | input | 2 | Per-queue software trigger pulse |
| timerTick | input | 1 | Periodic timer expiry pulse |
| extTrig | input | 2 | Per-queue external trigger lines |
| gateIn | input | 1 | Gate level for queue 1 |
| flagClr | input | 6 | Write-one-to-clear for flags |
| doneIe | input | 2 | Completion interrupt enables |
| pauseIe | input | 2 | Pause interrupt enables |
| convCh | output | 6 | Channel for the conversion engine |
| convSt | output | 2 | Sample-time code for the engine |
| convStart | output | 1 | Conversion start pulse |
| convAbort | output | 1 | Conversion abort strobe |
| convDone | input | 1 | Conversion finished strobe |
| convResult | input | RES_W | Conversion result |
| resWr | output | 1 | Result table write strobe |
| resIdx | output | IDX_W | Result table write index |
| resData | output | RES_W | Result table write data |
| doneFlag | output | 2 | Per-queue pass completion flags |
| pauseFlag | output | 2 | Per-queue pause flags |
| ovrFlag | output | 2 | Per-queue trigger overrun flags |
| irq | output | 2 | Per-queue interrupt requests |

## Verification
The bench builds the block with DEPTH = 16 and RES_W = 10. At that depth the physical-end condition is reached within a few dozen conversions. This makes it practical to sweep the queue boundary over every value from 0 to 15 and confirm that each pass converts exactly the expected index range. The bench models the engine with a latency set by the sample-time code, and its result encodes the channel and code. Every write can therefore be checked against the command stored at that index. Directed runs on the same small memory cover the end marker, a pause followed by a preemption with its subqueue restart, both scan modes, each trigger source, overrun and the flag and interrupt logic.

// File: rtl/dualq_pkg.sv
`timescale 1ns/1ps
package dualq_pkg;
  localparam int CH_W = 6;
  localparam logic [CH_W-1:0] CH_END = '1;

  typedef struct packed {
    logic            pause;
    logic [1:0]      sampleCode;
    logic [CH_W-1:0] chan;
  } cmdWord_t;

  localparam int CMD_W = $bits(cmdWord_t);

  typedef struct packed {
    logic launch;
    logic abort;
    logic store;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SRC_SW    = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_EDGE  = 2'd2,
    SRC_GATE  = 2'd3
  } trigSrc_e;
endpackage

// File: rtl/dualq_dpath.sv
`timescale 1ns/1ps
module dualq_dpath
  import dualq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic [IDX_W-1:0] cmdAddr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic [IDX_W-1:0] rdIdx,
  input  seqStrobe_t       stb,
  output logic             cmdPause,
  output logic [CH_W-1:0]  cmdChan,
  output logic [CH_W-1:0]  convCh,
  output logic [1:0]       convSt,
  output logic             convStart,
  output logic             convAbort,
  input  logic [RES_W-1:0] convResult,
  output logic             resWr,
  output logic [IDX_W-1:0] resIdx,
  output logic [RES_W-1:0] resData
);
  logic [CMD_W-1:0] cmdMem [DEPTH];
  cmdWord_t         rdWord;
  logic [IDX_W-1:0] curIdx;

  always_ff @(posedge clk) begin
    if (cmdWe) cmdMem[cmdAddr] <= cmdData;
  end

  assign rdWord   = cmdWord_t'(cmdMem[rdIdx]);
  assign cmdPause = rdWord.pause;
  assign cmdChan  = rdWord.chan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStart <= 1'b0;
      curIdx    <= '0;
      convCh    <= '0;
      convSt    <= '0;
    end else begin
      convStart <= stb.launch;
      if (stb.launch) begin
        curIdx <= rdIdx;
        convCh <= rdWord.chan;
        convSt <= rdWord.sampleCode;
      end
    end
  end

  assign convAbort = stb.abort;
  assign resWr     = stb.store;
  assign resIdx    = curIdx;
  assign resData   = convResult;

  // R1
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R7
  abort_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    convAbort |=> !convStart);
endmodule

// File: rtl/dualq_ctrl.sv
`timescale 1ns/1ps
module dualq_ctrl
  import dualq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] q2Start,
  input  logic [1:0]       q1Src,
  input  logic [1:0]       q2Src,
  input  logic [1:0]       scanCont,
  input  logic [1:0]       armSet,
  input  logic [1:0]       swTrig,
  input  logic             timerTick,
  input  logic [1:0]       extTrig,
  input  logic             gateIn,
  input  logic [5:0]       flagClr,
  input  logic [1:0]       doneIe,
  input  logic [1:0]       pauseIe,
  input  logic             cmdPause,
  input  logic [CH_W-1:0]  cmdChan,
  input  logic             convDone,
  output logic [IDX_W-1:0] rdIdx,
  output seqStrobe_t       stb,
  output logic [1:0]       doneFlag,
  output logic [1:0]       pauseFlag,
  output logic [1:0]       ovrFlag,
  output logic [1:0]       irq
);
  typedef enum logic {ST_IDLE, ST_CONV} state_e;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  state_e           state;
  logic             curQ, curPause;
  logic [1:0]       armed, busy, paused, extPrev;
  logic [IDX_W-1:0] ptr1, ptr2, sub2;

  logic [1:0] ev, running, startQ, resumeQ, ovrQ, finVec, parkVec, pauseSet, advVec;
  logic       preempt, selQ, dispatch, endHit, convEnd, lastIdx;

  function automatic logic srcHit(trigSrc_e sel, logic sw, logic tick, logic edgeEv, logic gate);
    case (sel)
      SRC_SW:    return sw;
      SRC_TIMER: return tick;
      SRC_EDGE:  return edgeEv;
      default:   return gate;
    endcase
  endfunction

  always_comb begin
    running = busy & ~paused;
    ev[0] = armed[0] & srcHit(trigSrc_e'(q1Src), swTrig[0], timerTick,
                              extTrig[0] & ~extPrev[0], gateIn);
    ev[1] = armed[1] & srcHit(trigSrc_e'(q2Src), swTrig[1], timerTick,
                              extTrig[1] & ~extPrev[1], 1'b0);
    startQ  = ev & ~busy;
    resumeQ = ev & busy & paused;
    ovrQ    = ev & running;
    if (trigSrc_e'(q1Src) == SRC_GATE) ovrQ[0] = 1'b0;
    preempt = (startQ[0] | resumeQ[0]) & running[1];
    selQ    = ~running[0];
    rdIdx   = ((state == ST_CONV) ? curQ : selQ) ? ptr2 : ptr1;
    lastIdx = (rdIdx == LAST_IDX);
    dispatch = (state == ST_IDLE) & (|running) & ~preempt;
    endHit   = (cmdChan == CH_END) | (~selQ & (ptr1 == q2Start));

    stb.abort  = preempt & (state == ST_CONV) & curQ;
    stb.launch = dispatch & ~endHit;
    convEnd    = (state == ST_CONV) & convDone & ~stb.abort;
    stb.store  = convEnd;

    finVec   = '0;
    parkVec  = '0;
    pauseSet = '0;
    advVec   = '0;
    if (dispatch & endHit) finVec[selQ] = 1'b1;
    if (convEnd) begin
      if (lastIdx) finVec[curQ] = 1'b1;
      else         advVec[curQ] = 1'b1;
      if (curPause) begin
        pauseSet[curQ] = 1'b1;
        if (!lastIdx) parkVec[curQ] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curQ     <= 1'b0;
      curPause <= 1'b0;
      armed    <= '0;
      busy     <= '0;
      paused   <= '0;
      extPrev  <= '0;
      ptr1     <= '0;
      ptr2     <= '0;
      sub2     <= '0;
      doneFlag <= '0;
      pauseFlag <= '0;
      ovrFlag  <= '0;
    end else begin
      extPrev <= extTrig;
      if (stb.abort) begin
        state <= ST_IDLE;
      end else if (stb.launch) begin
        state    <= ST_CONV;
        curQ     <= selQ;
        curPause <= cmdPause;
      end else if (convEnd) begin
        state <= ST_IDLE;
      end

      for (int q = 0; q < 2; q++) begin
        if (startQ[q])      busy[q] <= 1'b1;
        else if (finVec[q]) busy[q] <= 1'b0;
        if (parkVec[q])     paused[q] <= 1'b1;
        else if (resumeQ[q] | finVec[q] | startQ[q]) paused[q] <= 1'b0;
        if (armSet[q])      armed[q] <= 1'b1;
        else if (finVec[q] & ~scanCont[q]) armed[q] <= 1'b0;
        if (finVec[q])      doneFlag[q] <= 1'b1;
        else if (flagClr[q]) doneFlag[q] <= 1'b0;
        if (pauseSet[q])    pauseFlag[q] <= 1'b1;
        else if (flagClr[q+2]) pauseFlag[q] <= 1'b0;
        if (ovrQ[q])        ovrFlag[q] <= 1'b1;
        else if (flagClr[q+4]) ovrFlag[q] <= 1'b0;
      end

      if (startQ[0])      ptr1 <= '0;
      else if (advVec[0]) ptr1 <= ptr1 + 1'b1;

      if (startQ[1]) begin
        ptr2 <= q2Start;
        sub2 <= q2Start;
      end else begin
        if (preempt)        ptr2 <= sub2;
        else if (advVec[1]) ptr2 <= ptr2 + 1'b1;
        if (finVec[1])       sub2 <= q2Start;
        else if (parkVec[1]) sub2 <= ptr2 + 1'b1;
      end
    end
  end

  assign irq = (doneFlag & doneIe) | (pauseFlag & pauseIe);

  // R9
  single_scan_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy[0]) && !$past(scanCont[0]) && !$past(armSet[0])) |-> !armed[0]);

  // R4
  q1_done_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy[0]) |-> doneFlag[0]);

  // R6
  q2_done_on_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy[1]) |-> doneFlag[1]);

  // R11
  overrun_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag[0]) |-> $past(busy[0]));
endmodule

// File: rtl/dualq_sequencer.sv
`timescale 1ns/1ps
module dualq_sequencer
  import dualq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int RES_W = 10,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWe,
  input  logic [IDX_W-1:0] cmdAddr,
  input  logic [CMD_W-1:0] cmdData,
  input  logic [IDX_W-1:0] q2Start,
  input  logic [1:0]       q1Src,
  input  logic [1:0]       q2Src,
  input  logic [1:0]       scanCont,
  input  logic [1:0]       armSet,
  input  logic [1:0]       swTrig,
  input  logic             timerTick,
  input  logic [1:0]       extTrig,
  input  logic             gateIn,
  input  logic [5:0]       flagClr,
  input  logic [1:0]       doneIe,
  input  logic [1:0]       pauseIe,
  output logic [CH_W-1:0]  convCh,
  output logic [1:0]       convSt,
  output logic             convStart,
  output logic             convAbort,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic             resWr,
  output logic [IDX_W-1:0] resIdx,
  output logic [RES_W-1:0] resData,
  output logic [1:0]       doneFlag,
  output logic [1:0]       pauseFlag,
  output logic [1:0]       ovrFlag,
  output logic [1:0]       irq
);
  seqStrobe_t       stb;
  logic [IDX_W-1:0] rdIdx;
  logic             cmdPause;
  logic [CH_W-1:0]  cmdChan;

  dualq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk, .rstN, .q2Start, .q1Src, .q2Src, .scanCont, .armSet, .swTrig,
    .timerTick, .extTrig, .gateIn, .flagClr, .doneIe, .pauseIe,
    .cmdPause, .cmdChan, .convDone, .rdIdx, .stb,
    .doneFlag, .pauseFlag, .ovrFlag, .irq
  );

  dualq_dpath #(.DEPTH(DEPTH), .RES_W(RES_W)) uDpath (
    .clk, .rstN, .cmdWe, .cmdAddr, .cmdData, .rdIdx, .stb,
    .cmdPause, .cmdChan, .convCh, .convSt, .convStart, .convAbort,
    .convResult, .resWr, .resIdx, .resData
  );
endmodule

// File: tb/dualq_sequencer_test.sv
`timescale 1ns/1ps
module dualq_sequencer_test;
  localparam int DEPTH = 16;
  localparam int RES_W = 10;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWe = 1'b0;
  logic [IDX_W-1:0] cmdAddr = '0, q2Start = '0;
  logic [8:0] cmdData = '0;
  logic [1:0] q1Src = '0, q2Src = '0, scanCont = '0, armSet = '0, swTrig = '0, extTrig = '0;
  logic [1:0] doneIe = '0, pauseIe = '0;
  logic timerTick = 1'b0, gateIn = 1'b0, convDone = 1'b0;
  logic [5:0] flagClr = '0;
  logic [RES_W-1:0] convResult = '0;
  logic [5:0] convCh;
  logic [1:0] convSt;
  logic convStart, convAbort, resWr;
  logic [IDX_W-1:0] resIdx;
  logic [RES_W-1:0] resData;
  logic [1:0] doneFlag, pauseFlag, ovrFlag, irq;

  dualq_sequencer #(.DEPTH(DEPTH), .RES_W(RES_W)) uut (.*);

  always #5 clk = ~clk;

  int nChk = 0, nFail = 0, nLog = 0, nAbort = 0;
  int logIdx [256];
  int logDat [256];
  int bCh [DEPTH];
  int bSt [DEPTH];
  int bPause [DEPTH];

  // conversion engine model: latency 2<<code cycles, result = {code, channel, 2'b01}
  int eCnt = 0;
  logic eBusy = 1'b0;
  logic [5:0] eCh = '0;
  logic [1:0] eSt = '0;
  always @(posedge clk) begin
    #2;
    convDone = 1'b0;
    if (convAbort) eBusy = 1'b0;
    else if (convStart) begin
      eBusy = 1'b1; eCnt = 2 << convSt; eCh = convCh; eSt = convSt;
    end else if (eBusy) begin
      eCnt--;
      if (eCnt == 0) begin
        eBusy = 1'b0; convDone = 1'b1; convResult = {eSt, eCh, 2'b01};
      end
    end
  end

  always @(negedge clk) begin
    if (resWr && nLog < 256) begin
      logIdx[nLog] = int'(resIdx); logDat[nLog] = int'(resData); nLog++;
    end
    if (convAbort) nAbort++;
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic waitCycles(input int n); repeat (n) tick(); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRes(input int i);
    return (bSt[i] << 8) | (bCh[i] << 2) | 1;
  endfunction

  task automatic loadCmds();
    for (int i = 0; i < DEPTH; i++) begin
      cmdWe = 1'b1; cmdAddr = IDX_W'(i);
      cmdData = {bPause[i][0], bSt[i][1:0], bCh[i][5:0]};
      tick();
    end
    cmdWe = 1'b0;
  endtask

  task automatic defaults();
    for (int i = 0; i < DEPTH; i++) begin
      bCh[i] = (i * 5 + 3) % 60; bSt[i] = i % 4; bPause[i] = 0;
    end
  endtask

  task automatic clearAll();
    flagClr = 6'h3F; tick(); flagClr = '0;
    nLog = 0; nAbort = 0;
  endtask

  task automatic arm(input int q); armSet[q] = 1'b1; tick(); armSet = '0; endtask
  task automatic fireSw(input int q); swTrig[q] = 1'b1; tick(); swTrig = '0; endtask

  task automatic waitDone(input int q, input string req);
    int n = 0;
    while (!doneFlag[q] && n < 4000) begin tick(); n++; end
    chk(doneFlag[q] == 1'b1, req, int'(doneFlag[q]), 1);
  endtask

  task automatic checkSeq(input string req, input int pos, input int first, input int count);
    for (int k = 0; k < count; k++) begin
      chk(logIdx[pos + k] == first + k, req, logIdx[pos + k], first + k);
      chk(logDat[pos + k] == expRes(first + k), req, logDat[pos + k], expRes(first + k));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    int base;
    defaults();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    // R13 reset state
    chk(doneFlag == 0 && pauseFlag == 0 && ovrFlag == 0, "R13 flags", int'({doneFlag, pauseFlag, ovrFlag}), 0);
    chk(irq == 0 && convStart == 0 && convAbort == 0 && resWr == 0, "R13 strobes", int'({irq, convStart, convAbort, resWr}), 0);
    fireSw(0); waitCycles(40);
    chk(nLog == 0, "R13 disarmed after reset", nLog, 0);
    loadCmds();

    // R5 R6 R2 R1: sweep the queue boundary
    for (int b = 0; b < DEPTH; b++) begin
      q2Start = IDX_W'(b);
      clearAll(); armSet = 2'b11; tick(); armSet = '0;
      fireSw(0); waitDone(0, "R5 q1 pass done");
      chk(nLog == b, "R5 q1 conversion count", nLog, b);
      checkSeq("R1 R2 q1 order and result", 0, 0, b);
      fireSw(1); waitDone(1, "R6 q2 pass done");
      chk(nLog == DEPTH, "R6 q2 runs to last index", nLog - b, DEPTH - b);
      checkSeq("R2 q2 order and result", b, b, DEPTH - b);
    end

    // R4 end marker in each queue
    q2Start = IDX_W'(8); bCh[3] = 63; bCh[11] = 63; loadCmds();
    clearAll(); armSet = 2'b11; tick(); armSet = '0;
    fireSw(0); waitDone(0, "R4 q1 marker done");
    chk(nLog == 3, "R4 q1 stops at marker", nLog, 3);
    fireSw(1); waitDone(1, "R4 q2 marker done");
    chk(nLog == 6, "R4 q2 stops at marker", nLog, 6);
    checkSeq("R4 q2 indices", 3, 8, 3);
    defaults();

    // R3 R7 R8 pause, preemption, subqueue restart
    q2Start = IDX_W'(4); bPause[6] = 1; loadCmds();
    clearAll(); armSet = 2'b11; tick(); armSet = '0;
    fireSw(1);
    for (int n = 0; n < 2000 && !pauseFlag[1]; n++) tick();
    chk(pauseFlag[1] == 1'b1, "R3 pause flag", int'(pauseFlag[1]), 1);
    waitCycles(60);
    chk(nLog == 3, "R3 queue halted", nLog, 3);
    chk(doneFlag[1] == 1'b0, "R3 not complete", int'(doneFlag[1]), 0);
    fireSw(1);
    for (int n = 0; n < 2000 && nLog < 5; n++) tick();
    waitCycles(2);
    fireSw(0);
    waitDone(0, "R7 q1 done after preempt");
    waitDone(1, "R8 q2 done after restart");
    chk(nAbort == 1, "R7 one abort strobe", nAbort, 1);
    checkSeq("R3 resume at next index", 0, 4, 5);
    checkSeq("R7 q1 runs, aborted index unwritten", 5, 0, 4);
    checkSeq("R8 restart at subqueue", 9, 7, DEPTH - 7);
    chk(nLog == 9 + DEPTH - 7, "R8 total writes", nLog, 9 + DEPTH - 7);
    defaults(); loadCmds();

    // R9 single-scan versus continuous
    q2Start = IDX_W'(3);
    clearAll(); arm(0); fireSw(0); waitDone(0, "R9 single pass");
    clearAll(); fireSw(0); waitCycles(100);
    chk(nLog == 0, "R9 single-scan disarmed", nLog, 0);
    chk(doneFlag[0] == 1'b0, "R9 no pass while disarmed", int'(doneFlag[0]), 0);
    scanCont[0] = 1'b1; arm(0);
    fireSw(0); waitDone(0, "R9 continuous pass 1");
    flagClr = 6'h01; tick(); flagClr = '0;
    fireSw(0); waitDone(0, "R9 continuous pass 2");
    chk(nLog == 6, "R9 continuous stays armed", nLog, 6);

    // R10 trigger sources
    q1Src = 2'd1; clearAll(); fireSw(0); waitCycles(60);
    chk(nLog == 0, "R10 sw ignored in timer mode", nLog, 0);
    timerTick = 1'b1; tick(); timerTick = 1'b0; waitDone(0, "R10 timer start");
    chk(nLog == 3, "R10 timer pass", nLog, 3);
    q1Src = 2'd2; clearAll(); extTrig[0] = 1'b1; waitDone(0, "R10 edge start");
    waitCycles(80);
    chk(nLog == 3, "R10 held level gives one edge", nLog, 3);
    extTrig[0] = 1'b0;
    q1Src = 2'd3; scanCont[0] = 1'b0; clearAll(); gateIn = 1'b1; waitDone(0, "R10 gate start");
    waitCycles(60); gateIn = 1'b0;
    chk(nLog == 3, "R10 gate single pass", nLog, 3);
    chk(ovrFlag[0] == 1'b0, "R11 no overrun in gate mode", int'(ovrFlag[0]), 0);
    q2Src = 2'd3; arm(1); clearAll(); gateIn = 1'b1; timerTick = 1'b1; swTrig[1] = 1'b1;
    tick(); timerTick = 1'b0; swTrig = '0; waitCycles(60); gateIn = 1'b0;
    chk(nLog == 0 && doneFlag[1] == 1'b0, "R10 q2 code 3 never triggers", nLog, 0);

    // R11 overrun
    q1Src = 2'd0; arm(0); clearAll(); fireSw(0); tick(); fireSw(0);
    waitDone(0, "R11 pass completes");
    chk(ovrFlag[0] == 1'b1, "R11 overrun flag", int'(ovrFlag[0]), 1);
    chk(nLog == 3, "R11 extra trigger ignored", nLog, 3);
    chk(ovrFlag[1] == 1'b0, "R11 other queue clean", int'(ovrFlag[1]), 0);

    // R12 flags and interrupts
    base = 0;
    chk(irq[0] == 1'b0, "R12 irq masked", int'(irq[0]), base);
    doneIe[0] = 1'b1; #1;
    chk(irq[0] == 1'b1, "R12 irq on done", int'(irq[0]), 1);
    flagClr = 6'b000001; tick(); flagClr = '0;
    chk(doneFlag[0] == 1'b0, "R12 done cleared by bit 0", int'(doneFlag[0]), 0);
    chk(ovrFlag[0] == 1'b1, "R12 overrun kept", int'(ovrFlag[0]), 1);
    chk(irq[0] == 1'b0, "R12 irq drops", int'(irq[0]), 0);
    flagClr = 6'b010000; tick(); flagClr = '0;
    chk(ovrFlag[0] == 1'b0, "R12 overrun cleared by bit 4", int'(ovrFlag[0]), 0);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule